// File: doc/BRIEF.md
# External Static Bus Cycle Sequencer

This block turns single internal read or write requests into timed cycles on an external bus for static memories and I/O devices. The top bits of the request address choose one of several areas. The sequencer drives that area's active-low chip select, a shared address strobe, a read strobe and two write strobes, one for the high byte and one for the low byte. When a read finishes, the read data comes back together with a done pulse.

The block runs on a fast clock at twice the bus state rate, so one bus state lasts two fast-clock ticks. This allows strobe edges on half-state boundaries. Each area has its own four-bit configuration register. It selects 2-state or 3-state access, an 8-bit or 16-bit data path, one chip-select stretch state before and after the strobes, and whether the read strobe is released half a state early.

All pin outputs come from registers. For that reason every pin waveform starts one fast tick after the request is accepted.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, every chip select and strobe is high, `rsp_done` is low and `req_ready` is high. Every area configuration resets to 0000, which means 3-state, 8-bit data path, no stretch, and read released at the end of the cycle.
- R2: The area is address bits [ADDR_W-1 -: AREA_W]. Only that area's `bus_cs_n` bit goes low, and only while a cycle is running. `bus_as_n` is low exactly when some chip select is low.
- R3: One byte cycle holds chip select low for 2*N ticks. N is 3, or 2 when configuration bit 0 is set. The strobes fall 2 ticks after chip select falls. A write strobe stays low for 2*(N-1) ticks.
- R4: When configuration bit 2 is set, each byte cycle gains 2 ticks before the strobes and 2 ticks after them. Only chip select, address strobe and address are active in those ticks. The strobe fall then moves to 4 ticks after chip select falls.
- R5: When configuration bit 3 is set, the read strobe is released 1 tick (half a state) earlier, so it is low for 2*(N-1)-1 ticks. Writes keep their full length.
- R6: On an 8-bit area (bit 1 clear), a request with both byte enables set makes two back-to-back byte cycles. The first is the high byte at the even address and the second is the low byte at the odd address. Only `bus_hwr_n` is used, and the data is on `bus_dout[15:8]`.
- R7: On a 16-bit area (bit 1 set), the request takes one cycle at the even address. `bus_hwr_n` is asserted when byte enable bit 1 is set (data bits 15:8) and `bus_lwr_n` when bit 0 is set (bits 7:0). Byte enables of 00 act as 11.
- R8: Read data is taken from the bus at the end of the last access state of each byte cycle. On a 16-bit area, byte lanes map directly. On an 8-bit area, each byte comes from `bus_din[15:8]`. Bytes that were not requested return zero.
- R9: `rsp_done` is high for exactly 2 ticks, starting right after the last chip-select tick. `rsp_rdata` is valid while it is high.
- R10: `req_ready` is low from acceptance until `rsp_done` ends, and high on the tick after. A request held valid during that time starts no extra bus cycle.
- R11: When `cfg_we` is high, `cfg_wdata` is written to the register of area `cfg_area`. A cycle uses the configuration captured when its request was accepted, so a write during a cycle does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two ticks per bus state |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_area | input | AREA_W | Area whose configuration is written |
| cfg_wdata | input | 4 | bit0 two-state, bit1 16-bit, bit2 CS stretch, bit3 early read release |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request is taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 16 | Write data, bits 15:8 for the even byte |
| req_be | input | 2 | Byte enables, bit1 even byte, bit0 odd byte |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Read data |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | NUM_AREAS | Active-low chip selects |
| bus_as_n | output | 1 | Active-low address strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_hwr_n | output | 1 | Active-low high-byte write strobe |
| bus_lwr_n | output | 1 | Active-low low-byte write strobe |
| bus_dout | output | 16 | Write data to the bus |
| bus_dout_en | output | 1 | Drive enable for write data |
| bus_din | input | 16 | Read data from the bus |

## Verification
A wrong phase counter or state register shows up within the same transfer as a chip select or strobe that is too long or too short, or as a strobe fall that moves away from its fixed offset after the chip-select fall. A wrong byte-sequencing state shows up as a missing or extra strobe pulse, a wrong address on the second byte, or a misplaced byte in `rsp_rdata` when `rsp_done` rises. A stale configuration capture is found in the first transfer after a mid-cycle configuration write, because the pulse lengths then no longer match the captured settings.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef struct packed {
    logic rd_early;
    logic cs_ext;
    logic wide;
    logic two_state;
  } area_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACC,
    ST_POST,
    ST_DONE
  } seq_st_t;

endpackage

// File: rtl/bsq_cfg_bank.sv
module bsq_cfg_bank
  import bsq_pkg::*;
#(
  parameter int NUM_AREAS = 4,
  localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AREA_W-1:0] wr_area,
  input  area_cfg_t         wr_cfg,
  input  logic [AREA_W-1:0] rd_area,
  output area_cfg_t         rd_cfg
);

  area_cfg_t cfg_q [NUM_AREAS];

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[a] <= '0;
      end else if (wr_en && (wr_area == AREA_W'(a))) begin
        cfg_q[a] <= wr_cfg;
      end
    end
  end

  assign rd_cfg = cfg_q[rd_area];

endmodule

// File: rtl/bsq_area_decode.sv
module bsq_area_decode #(
  parameter int ADDR_W    = 16,
  parameter int NUM_AREAS = 4,
  localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [AREA_W-1:0]    addr_area,
  input  logic [AREA_W-1:0]    sel_area,
  output logic [NUM_AREAS-1:0] sel_onehot
);

  assign addr_area = addr[ADDR_W-1 -: AREA_W];

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_sel
    assign sel_onehot[a] = (sel_area == AREA_W'(a));
  end

endmodule

// File: rtl/bsq_cycle_fsm.sv
module bsq_cycle_fsm
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AREA_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  input  area_cfg_t         req_cfg,
  input  logic [AREA_W-1:0] req_area,
  input  logic [15:0]       bus_din,
  output logic              ready,
  output seq_st_t           st,
  output logic [2:0]        cnt,
  output area_cfg_t         cfg,
  output logic              wr,
  output logic [AREA_W-1:0] area,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [15:0]       cyc_dout,
  output logic              sel_hi,
  output logic              sel_lo,
  output logic [15:0]       rdata
);

  seq_st_t           st_q;
  logic [2:0]        cnt_q;
  logic              ready_q;
  area_cfg_t         cfg_q;
  logic              wr_q;
  logic [AREA_W-1:0] area_q;
  logic [ADDR_W-1:0] base_q;
  logic [15:0]       wdata_q;
  logic              hi_q, lo_q, pend_q;
  logic [15:0]       rdata_q;
  logic              take_q, take_hi_q, take_lo_q;

  logic       accept;
  logic [2:0] acc_last;
  logic [1:0] be_eff;

  assign accept   = req_valid && ready_q;
  assign acc_last = cfg_q.two_state ? 3'd3 : 3'd5;
  assign be_eff   = (req_be == 2'b00) ? 2'b11 : req_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      ready_q   <= 1'b1;
      cfg_q     <= '0;
      wr_q      <= 1'b0;
      area_q    <= '0;
      base_q    <= '0;
      wdata_q   <= '0;
      hi_q      <= 1'b0;
      lo_q      <= 1'b0;
      pend_q    <= 1'b0;
      rdata_q   <= '0;
      take_q    <= 1'b0;
      take_hi_q <= 1'b0;
      take_lo_q <= 1'b0;
    end else begin
      take_q    <= (st_q == ST_ACC) && (cnt_q == acc_last) && !wr_q;
      take_hi_q <= hi_q;
      take_lo_q <= lo_q;
      ready_q   <= (st_q == ST_IDLE) && !accept;

      if (take_q) begin
        if (cfg_q.wide) begin
          if (take_hi_q) rdata_q[15:8] <= bus_din[15:8];
          if (take_lo_q) rdata_q[7:0]  <= bus_din[7:0];
        end else if (take_lo_q) begin
          rdata_q[7:0]  <= bus_din[15:8];
        end else begin
          rdata_q[15:8] <= bus_din[15:8];
        end
      end

      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            cfg_q   <= req_cfg;
            wr_q    <= req_write;
            area_q  <= req_area;
            base_q  <= req_addr;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            cnt_q   <= '0;
            st_q    <= req_cfg.cs_ext ? ST_PRE : ST_ACC;
            if (req_cfg.wide) begin
              hi_q   <= be_eff[1];
              lo_q   <= be_eff[0];
              pend_q <= 1'b0;
            end else begin
              hi_q   <= be_eff[1];
              lo_q   <= !be_eff[1];
              pend_q <= be_eff[1] && be_eff[0];
            end
          end
        end
        ST_PRE: begin
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd1) begin
            st_q  <= ST_ACC;
            cnt_q <= '0;
          end
        end
        ST_ACC, ST_POST: begin
          cnt_q <= cnt_q + 3'd1;
          if (st_q == ST_ACC && cnt_q == acc_last && cfg_q.cs_ext) begin
            st_q  <= ST_POST;
            cnt_q <= '0;
          end else if ((st_q == ST_ACC && cnt_q == acc_last) ||
                       (st_q == ST_POST && cnt_q == 3'd1)) begin
            cnt_q <= '0;
            if (pend_q) begin
              pend_q <= 1'b0;
              hi_q   <= 1'b0;
              lo_q   <= 1'b1;
              st_q   <= cfg_q.cs_ext ? ST_PRE : ST_ACC;
            end else begin
              st_q <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd1) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready    = ready_q;
  assign st       = st_q;
  assign cnt      = cnt_q;
  assign cfg      = cfg_q;
  assign wr       = wr_q;
  assign area     = area_q;
  assign sel_hi   = hi_q;
  assign sel_lo   = lo_q;
  assign rdata    = rdata_q;
  assign cyc_addr = cfg_q.wide ? {base_q[ADDR_W-1:1], 1'b0} : {base_q[ADDR_W-1:1], lo_q};
  assign cyc_dout = cfg_q.wide ? wdata_q
                               : {(lo_q ? wdata_q[7:0] : wdata_q[15:8]), 8'h00};

endmodule

// File: rtl/bsq_pin_decode.sv
module bsq_pin_decode
  import bsq_pkg::*;
#(
  parameter int NUM_AREAS = 4
) (
  input  seq_st_t              st,
  input  logic [2:0]           cnt,
  input  area_cfg_t            cfg,
  input  logic                 wr,
  input  logic                 sel_hi,
  input  logic                 sel_lo,
  input  logic [NUM_AREAS-1:0] area_sel,
  output logic [NUM_AREAS-1:0] cs_n,
  output logic                 as_n,
  output logic                 rd_n,
  output logic                 hwr_n,
  output logic                 lwr_n,
  output logic                 dout_en
);

  logic       active;
  logic       win;
  logic [2:0] strb_end;

  always_comb begin
    active   = (st == ST_PRE) || (st == ST_ACC) || (st == ST_POST);
    strb_end = (cfg.two_state ? 3'd4 : 3'd6) - ((cfg.rd_early && !wr) ? 3'd1 : 3'd0);
    win      = (st == ST_ACC) && (cnt >= 3'd2) && (cnt < strb_end);
    cs_n     = active ? ~area_sel : '1;
    as_n     = !active;
    rd_n     = !(win && !wr);
    hwr_n    = !(win && wr && (cfg.wide ? sel_hi : 1'b1));
    lwr_n    = !(win && wr && cfg.wide && sel_lo);
    dout_en  = active && wr;
  end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_AREAS = 4,
  localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [AREA_W-1:0]    cfg_area,
  input  logic [3:0]           cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [15:0]          req_wdata,
  input  logic [1:0]           req_be,
  output logic                 rsp_done,
  output logic [15:0]          rsp_rdata,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_AREAS-1:0] bus_cs_n,
  output logic                 bus_as_n,
  output logic                 bus_rd_n,
  output logic                 bus_hwr_n,
  output logic                 bus_lwr_n,
  output logic [15:0]          bus_dout,
  output logic                 bus_dout_en,
  input  logic [15:0]          bus_din
);

  logic [AREA_W-1:0]    req_area, cur_area;
  logic [NUM_AREAS-1:0] area_sel;
  area_cfg_t            req_cfg, cur_cfg;
  seq_st_t              st;
  logic [2:0]           cnt;
  logic                 wr, sel_hi, sel_lo;
  logic [ADDR_W-1:0]    cyc_addr;
  logic [15:0]          cyc_dout;

  logic [NUM_AREAS-1:0] cs_n_d;
  logic                 as_n_d, rd_n_d, hwr_n_d, lwr_n_d, dout_en_d;

  bsq_cfg_bank #(.NUM_AREAS(NUM_AREAS)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_area (cfg_area),
    .wr_cfg  (area_cfg_t'(cfg_wdata)),
    .rd_area (req_area),
    .rd_cfg  (req_cfg)
  );

  bsq_area_decode #(.ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS)) u_dec (
    .addr       (req_addr),
    .addr_area  (req_area),
    .sel_area   (cur_area),
    .sel_onehot (area_sel)
  );

  bsq_cycle_fsm #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .req_cfg   (req_cfg),
    .req_area  (req_area),
    .bus_din   (bus_din),
    .ready     (req_ready),
    .st        (st),
    .cnt       (cnt),
    .cfg       (cur_cfg),
    .wr        (wr),
    .area      (cur_area),
    .cyc_addr  (cyc_addr),
    .cyc_dout  (cyc_dout),
    .sel_hi    (sel_hi),
    .sel_lo    (sel_lo),
    .rdata     (rsp_rdata)
  );

  bsq_pin_decode #(.NUM_AREAS(NUM_AREAS)) u_pins (
    .st       (st),
    .cnt      (cnt),
    .cfg      (cur_cfg),
    .wr       (wr),
    .sel_hi   (sel_hi),
    .sel_lo   (sel_lo),
    .area_sel (area_sel),
    .cs_n     (cs_n_d),
    .as_n     (as_n_d),
    .rd_n     (rd_n_d),
    .hwr_n    (hwr_n_d),
    .lwr_n    (lwr_n_d),
    .dout_en  (dout_en_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs_n    <= '1;
      bus_as_n    <= 1'b1;
      bus_rd_n    <= 1'b1;
      bus_hwr_n   <= 1'b1;
      bus_lwr_n   <= 1'b1;
      bus_dout_en <= 1'b0;
      bus_addr    <= '0;
      bus_dout    <= '0;
      rsp_done    <= 1'b0;
    end else begin
      bus_cs_n    <= cs_n_d;
      bus_as_n    <= as_n_d;
      bus_rd_n    <= rd_n_d;
      bus_hwr_n   <= hwr_n_d;
      bus_lwr_n   <= lwr_n_d;
      bus_dout_en <= dout_en_d;
      bus_addr    <= cyc_addr;
      bus_dout    <= cyc_dout;
      rsp_done    <= (st == ST_DONE);
    end
  end

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int NUM_AREAS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_ready,
  input logic                 rsp_done,
  input logic [NUM_AREAS-1:0] bus_cs_n,
  input logic                 bus_as_n,
  input logic                 bus_rd_n,
  input logic                 bus_hwr_n,
  input logic                 bus_lwr_n
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (&bus_cs_n && bus_rd_n && bus_hwr_n && bus_lwr_n && !rsp_done));

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));

  // R2
  as_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_as_n == (&bus_cs_n));

  // R3
  strobe_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_hwr_n || !bus_lwr_n) |-> !(&bus_cs_n));

  // R4
  strobe_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_rd_n) || $fell(bus_hwr_n) || $fell(bus_lwr_n)) |-> !$past(&bus_cs_n));

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (bus_hwr_n && bus_lwr_n));

  // R9
  done_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_done) |=> rsp_done);

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && $past(rsp_done)) |=> !rsp_done);

  // R10
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&bus_cs_n) || rsp_done) |-> !req_ready);

endmodule

bind ext_bus_seq bsq_checker #(.NUM_AREAS(NUM_AREAS)) u_bsq_checker (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .bus_cs_n  (bus_cs_n),
  .bus_as_n  (bus_as_n),
  .bus_rd_n  (bus_rd_n),
  .bus_hwr_n (bus_hwr_n),
  .bus_lwr_n (bus_lwr_n)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NUM_AREAS  = 4;
  localparam int AREA_W     = 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 cfg_we = 1'b0;
  logic [AREA_W-1:0]    cfg_area = '0;
  logic [3:0]           cfg_wdata = '0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic                 req_write = 1'b0;
  logic [ADDR_W-1:0]    req_addr = '0;
  logic [15:0]          req_wdata = '0;
  logic [1:0]           req_be = '0;
  logic                 rsp_done;
  logic [15:0]          rsp_rdata;
  logic [ADDR_W-1:0]    bus_addr;
  logic [NUM_AREAS-1:0] bus_cs_n;
  logic                 bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n, bus_dout_en;
  logic [15:0]          bus_dout;
  logic [15:0]          bus_din;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] mcfg [NUM_AREAS];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] din_of(input logic [15:0] a);
    return {a[7:0] ^ a[15:8] ^ 8'h3C, a[7:0] + 8'h11};
  endfunction

  assign bus_din = din_of(bus_addr);

  ext_bus_seq #(.ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS)) i_ext_bus_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_as_n(bus_as_n), .bus_rd_n(bus_rd_n),
    .bus_hwr_n(bus_hwr_n), .bus_lwr_n(bus_lwr_n), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // R11: configuration write, bit0 two-state, bit1 wide, bit2 stretch, bit3 early read
  task automatic cfg_write(input logic [AREA_W-1:0] a, input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_area = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    mcfg[a] = v;
  endtask

  task automatic xfer(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                      input logic [1:0] be, input bit hold, input bit mid, input logic [3:0] mid_v);
    logic [3:0] c;
    logic [1:0] be_e, area;
    int n, e, cyc, wlen, rlen, nb, t, csfall, cslow, badcs, badas, np, rdl, hwl, lwl;
    int busy_rdy, dstart, dcnt;
    int pos [2];
    logic [15:0] paddr [2];
    logic [15:0] pdout [2];
    logic [15:0] rd_s, exp_rd, ea, ed, even;
    bit prev_s, strb, rdy_end;
    area = addr[15:14];
    c = mcfg[area];
    be_e = (be == 2'b00) ? 2'b11 : be;
    n = c[0] ? 2 : 3;
    e = c[2] ? 1 : 0;
    cyc = 2 * (n + 2 * e);
    wlen = 2 * (n - 1);
    rlen = wlen - (c[3] ? 1 : 0);
    nb = c[1] ? 1 : ((be_e == 2'b11) ? 2 : 1);
    even = {addr[15:1], 1'b0};
    csfall = -1; cslow = 0; badcs = 0; badas = 0; np = 0; rdl = 0; hwl = 0; lwl = 0;
    busy_rdy = 0; dstart = -1; dcnt = 0; prev_s = 0; rd_s = '0; rdy_end = 0;
    pos[0] = 0; pos[1] = 0; paddr[0] = '0; paddr[1] = '0; pdout[0] = '0; pdout[1] = '0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    for (t = 0; t < 300; t++) begin
      if (mid && t == 3) begin cfg_we = 1'b1; cfg_area = area; cfg_wdata = mid_v; end
      if (mid && t == 4) cfg_we = 1'b0;
      if (dcnt > 0 && !rsp_done) begin
        rdy_end = req_ready;
        break;
      end
      if (!(&bus_cs_n)) begin
        if (csfall < 0) csfall = t;
        cslow++;
        if (bus_cs_n != ~(4'b0001 << area)) badcs++;
      end
      if (bus_as_n != (&bus_cs_n)) badas++;
      strb = !bus_rd_n || !bus_hwr_n || !bus_lwr_n;
      if (strb && !prev_s) begin
        if (np < 2) begin pos[np] = t; paddr[np] = bus_addr; pdout[np] = bus_dout; end
        np++;
      end
      prev_s = strb;
      rdl += int'(!bus_rd_n);
      hwl += int'(!bus_hwr_n);
      lwl += int'(!bus_lwr_n);
      if (req_ready) busy_rdy++;
      if (rsp_done) begin
        if (dstart < 0) dstart = t;
        dcnt++;
        rd_s = rsp_rdata;
      end
      @(negedge clk);
    end
    if (hold) req_valid = 1'b0;
    if (mid) mcfg[area] = mid_v;

    chk(badcs == 0, "R2 chip select of other area or wrong area", badcs, 0);
    chk(badas == 0, "R2 address strobe not following chip select", badas, 0);
    chk(cslow == nb * cyc, "R3/R4 chip select low ticks", cslow, nb * cyc);
    chk(np == nb, "R6/R7 strobe pulse count", np, nb);
    chk(pos[0] - csfall == 2 + 2 * e, "R4 first strobe offset", pos[0] - csfall, 2 + 2 * e);
    if (nb == 2)
      chk(pos[1] - csfall == cyc + 2 + 2 * e, "R6 second byte strobe offset", pos[1] - csfall, cyc + 2 + 2 * e);
    chk(rdl == (wr ? 0 : nb * rlen), "R5 read strobe low ticks", rdl, wr ? 0 : nb * rlen);
    chk(hwl == (!wr ? 0 : (c[1] ? (be_e[1] ? wlen : 0) : nb * wlen)), "R3/R7 high write strobe ticks",
        hwl, (!wr ? 0 : (c[1] ? (be_e[1] ? wlen : 0) : nb * wlen)));
    chk(lwl == ((wr && c[1] && be_e[0]) ? wlen : 0), "R6/R7 low write strobe ticks",
        lwl, (wr && c[1] && be_e[0]) ? wlen : 0);
    for (int k = 0; k < nb && k < 2; k++) begin
      if (c[1]) begin
        ea = even; ed = wd;
      end else begin
        ea = (k == 0 && be_e[1]) ? even : (even | 16'h1);
        ed = {((ea[0]) ? wd[7:0] : wd[15:8]), 8'h00};
      end
      chk(paddr[k] == ea, "R6/R7 strobe address", paddr[k], ea);
      if (wr) chk(pdout[k] == ed, "R6/R7 write data on bus", pdout[k], ed);
    end
    if (!wr) begin
      if (c[1])
        exp_rd = {(be_e[1] ? din_of(even)[15:8] : 8'h00), (be_e[0] ? din_of(even)[7:0] : 8'h00)};
      else
        exp_rd = {(be_e[1] ? din_of(even)[15:8] : 8'h00), (be_e[0] ? din_of(even | 16'h1)[15:8] : 8'h00)};
      chk(rd_s == exp_rd, "R8 read data", rd_s, exp_rd);
    end
    chk(dcnt == 2, "R9 done length", dcnt, 2);
    chk(dstart == csfall + nb * cyc, "R9 done position", dstart - csfall, nb * cyc);
    chk(busy_rdy == 0, "R10 ready while busy", busy_rdy, 0);
    chk(rdy_end, "R10 ready after done", rdy_end, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R9 watchdog act=%0d exp=0", 1);
    summary();
  end

  initial begin
    for (int a = 0; a < NUM_AREAS; a++) mcfg[a] = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_cs_n == 4'hF, "R1 chip selects after reset", bus_cs_n, 4'hF);
    chk(bus_rd_n && bus_hwr_n && bus_lwr_n, "R1 strobes after reset", {bus_rd_n, bus_hwr_n, bus_lwr_n}, 3'b111);
    chk(req_ready && !rsp_done, "R1 ready and done after reset", {req_ready, rsp_done}, 2'b10);

    // R1 default 3-state 8-bit, R6 split, R8 assembly
    xfer(0, 16'h4122, 16'h0, 2'b11, 0, 0, 4'h0);
    xfer(1, 16'h0010, 16'hA55A, 2'b11, 0, 0, 4'h0);
    xfer(1, 16'h8031, 16'h1234, 2'b01, 0, 0, 4'h0);
    xfer(0, 16'h8031, 16'h0, 2'b10, 0, 0, 4'h0);
    // R7 wide area
    cfg_write(2'd2, 4'b0010);
    xfer(1, 16'h8100, 16'hBEEF, 2'b11, 0, 0, 4'h0);
    xfer(1, 16'h8101, 16'hC0DE, 2'b01, 0, 0, 4'h0);
    xfer(1, 16'h8102, 16'h7E57, 2'b00, 0, 0, 4'h0);
    xfer(0, 16'h8104, 16'h0, 2'b10, 0, 0, 4'h0);
    // R4 R5 stretch and early read
    cfg_write(2'd3, 4'b1100);
    xfer(0, 16'hC0F0, 16'h0, 2'b11, 0, 0, 4'h0);
    cfg_write(2'd3, 4'b0111);
    xfer(1, 16'hC0F2, 16'h5678, 2'b11, 0, 0, 4'h0);
    xfer(0, 16'hC0F4, 16'h0, 2'b11, 0, 0, 4'h0);
    // R10 held request
    xfer(0, 16'h4444, 16'h0, 2'b11, 1, 0, 4'h0);
    // R11 mid-cycle config write
    xfer(0, 16'h4500, 16'h0, 2'b11, 0, 1, 4'b1111);
    xfer(0, 16'h4502, 16'h0, 2'b11, 0, 0, 4'h0);

    void'($urandom(32'd4711));
    for (int i = 0; i < 60; i++) begin
      if (($urandom % 3) == 0) cfg_write(2'($urandom % 4), 4'($urandom));
      xfer(1'($urandom), 16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom % 5 == 0), 0, 4'h0);
    end
    summary();
  end

endmodule